// File: doc/BRIEF.md
# Ring Buffer Pointer and Fill-Level Controller

This block keeps the bookkeeping for a circular buffer that occupies a window of an external, word-addressed memory. The window starts at a fixed base address and holds a fixed number of words. A producer engine pulses a one-cycle write strobe each time it stores a word at the current write address. A consumer engine pulses a one-cycle read strobe each time it fetches a word from the current read address. The block moves both addresses, tracks how many words are held, and raises two flow-control flags. The memory and the data path belong to the engines, not to this block.

The flags do not mean plain full and empty. Each compares the fill level against a threshold that is set by a parameter. The producer may store while the level is below the store threshold. The consumer may fetch while the level is strictly above the fetch threshold. With the default thresholds of the depth and zero, the flags become ordinary not-full and not-empty. Other values make the producer stop early, or make the consumer wait until a batch has built up.

Top module: `ring_ptr_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, the write address and the read address both equal BASE, and the level is 0.
- R2: A write strobe sampled at a rising clock edge moves the write address up by one at that edge, so the new value is visible in the following cycle. Without a write strobe the write address holds.
- R3: A read strobe sampled at a rising clock edge moves the read address up by one at that edge. Without a read strobe the read address holds.
- R4: An address that advances from BASE+DEPTH-1 goes back to BASE, so both addresses always stay within BASE to BASE+DEPTH-1. DEPTH need not be a power of two.
- R5: A write strobe without a read strobe raises the level by one at the next edge.
- R6: A read strobe without a write strobe lowers the level by one at the next edge.
- R7: A write strobe and a read strobe in the same cycle leave the level unchanged, while both addresses still advance.
- R8: `writable` is 1 exactly when level < WR_TH. It follows the level in the same cycle, with no extra register.
- R9: `readable` is 1 exactly when level > RD_TH (strictly greater). It follows the level in the same cycle.
- R10: With the default thresholds (RD_TH = 0, WR_TH = DEPTH), `writable` is 0 only at level DEPTH, and `readable` is 0 only at level 0.
- R11: The level output is wide enough to show a count equal to DEPTH, and it reads DEPTH after DEPTH writes with no reads.
- R12: Engines strobe write only while `writable` is 1, and strobe read only while `readable` is 1. Under that rule the level stays within 0 to DEPTH. A strobe that breaks the rule is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | One word stored at `wr_addr` this cycle |
| rd_stb | input | 1 | One word fetched from `rd_addr` this cycle |
| wr_addr | output | ADDR_W | Memory address for the next store |
| rd_addr | output | ADDR_W | Memory address for the next fetch |
| level | output | $clog2(DEPTH)+1 | Number of words held |
| writable | output | 1 | Producer may store (level < WR_TH) |
| readable | output | 1 | Consumer may fetch (level > RD_TH) |

## Verification
The hardest state to reach is a pointer wrap while the level sits in the middle of the range. A run of writes alone cannot take the level above DEPTH, so it cannot carry the write address around the ring by much. The bench first fills and then partly drains the buffer. It then issues simultaneous read and write strobes for longer than DEPTH cycles, which wraps both addresses while the level stays fixed. A second instance uses a depth that is not a power of two and non-default thresholds. It is driven by seeded random strobes that obey the flags, so it crosses both threshold edges many times from each side.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

  // Next ring index: wraps to zero after the last slot.
  function automatic logic [31:0] idx_next(input logic [31:0] cur,
                                           input logic [31:0] last);
    return (cur == last) ? 32'd0 : cur + 32'd1;
  endfunction

  // Next fill count from the net direction of this cycle.
  function automatic logic [31:0] lvl_next(input logic [31:0] cur,
                                           input logic up,
                                           input logic dn);
    logic [31:0] r;
    r = cur;
    if (up && !dn)      r = cur + 32'd1;
    else if (dn && !up) r = cur - 32'd1;
    return r;
  endfunction

  // Store permission: count below the stop mark.
  function automatic logic below_mark(input logic [31:0] cnt,
                                      input logic [31:0] mark);
    return cnt < mark;
  endfunction

  // Fetch permission: count strictly above the start mark.
  function automatic logic above_mark(input logic [31:0] cnt,
                                      input logic [31:0] mark);
    return cnt > mark;
  endfunction

endpackage

// File: rtl/ring_index_counter.sv
module ring_index_counter
  import ring_ptr_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [31:0] LAST = 32'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (adv) idx_d = IDX_W'(idx_next(32'(idx_q), LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx     = idx_q;
  assign at_last = (32'(idx_q) == LAST);
endmodule

// File: rtl/ring_level_tracker.sv
module ring_level_tracker
  import ring_ptr_pkg::*;
#(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] lvl_d;

  always_comb lvl_d = LVL_W'(lvl_next(32'(lvl_q), inc, dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign level = lvl_q;
endmodule

// File: rtl/ring_flag_gen.sv
module ring_flag_gen
  import ring_ptr_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned RD_TH = 0,
  parameter int unsigned WR_TH = 16
) (
  input  logic [LVL_W-1:0] level,
  output logic             writable,
  output logic             readable
);
  localparam logic [31:0] WR_MARK = 32'(WR_TH);
  localparam logic [31:0] RD_MARK = 32'(RD_TH);

  assign writable = below_mark(32'(level), WR_MARK);
  assign readable = above_mark(32'(level), RD_MARK);
endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl #(
  parameter int unsigned           ADDR_W = 32,
  parameter logic [ADDR_W-1:0]     BASE   = '0,
  parameter int unsigned           DEPTH  = 16,
  parameter int unsigned           RD_TH  = 0,
  parameter int unsigned           WR_TH  = DEPTH,
  localparam int unsigned          IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned          LVL_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LVL_W-1:0]  level,
  output logic              writable,
  output logic              readable
);
  // Named internal events, visible to the bound checker.
  logic wr_adv, rd_adv;
  logic wr_wrap, rd_wrap;
  logic lvl_up, lvl_dn;

  logic [1:0]             adv_v;
  logic [1:0]             last_v;
  logic [IDX_W-1:0]       idx_v [2];
  logic [ADDR_W-1:0]      addr_v [2];

  assign wr_adv = wr_stb;
  assign rd_adv = rd_stb;
  assign adv_v  = {rd_adv, wr_adv};
  assign lvl_up = wr_stb & ~rd_stb;
  assign lvl_dn = rd_stb & ~wr_stb;

  // Slot 0 is the store pointer, slot 1 the fetch pointer.
  for (genvar p = 0; p < 2; p++) begin : g_ptr
    ring_index_counter #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv_v[p]),
      .idx     (idx_v[p]),
      .at_last (last_v[p])
    );
    assign addr_v[p] = BASE + ADDR_W'(idx_v[p]);
  end

  assign wr_addr = addr_v[0];
  assign rd_addr = addr_v[1];
  assign wr_wrap = wr_adv & last_v[0];
  assign rd_wrap = rd_adv & last_v[1];

  ring_level_tracker #(
    .LVL_W (LVL_W)
  ) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_stb),
    .dec   (rd_stb),
    .level (level)
  );

  ring_flag_gen #(
    .LVL_W (LVL_W),
    .RD_TH (RD_TH),
    .WR_TH (WR_TH)
  ) u_flags (
    .level    (level),
    .writable (writable),
    .readable (readable)
  );
endmodule

// File: rtl/ring_ptr_ctrl_chk.sv
module ring_ptr_ctrl_chk #(
  parameter int unsigned       ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  parameter int unsigned       DEPTH  = 16,
  parameter int unsigned       RD_TH  = 0,
  parameter int unsigned       WR_TH  = 16,
  parameter int unsigned       LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [LVL_W-1:0]  level,
  input logic              writable,
  input logic              readable,
  input logic              wr_wrap,
  input logic              rd_wrap,
  input logic              lvl_up,
  input logic              lvl_dn
);
  localparam int WT_M1 = int'(WR_TH) - 1;
  localparam int RT_P1 = int'(RD_TH) + 1;

  assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_wrap) |=> wr_addr == $past(wr_addr) + ADDR_W'(1));
  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(wr_addr));
  assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_wrap) |=> rd_addr == $past(rd_addr) + ADDR_W'(1));
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_addr));
  assert_wr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wrap |=> wr_addr == BASE);
  assert_rd_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrap |=> rd_addr == BASE);
  assert_lvl_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_up |=> level == $past(level) + LVL_W'(1));
  assert_lvl_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_dn |=> level == $past(level) - LVL_W'(1));
  assert_lvl_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rd_stb) |=> $stable(level));
  assert_wr_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_up && int'(level) == WT_M1) |=> !writable);
  assert_wr_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_dn && int'(level) == int'(WR_TH)) |=> writable);
  assert_rd_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_up && int'(level) == int'(RD_TH)) |=> readable);
  assert_rd_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_dn && int'(level) == RT_P1) |=> !readable);
  assert_lvl_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= 32'(DEPTH));
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> writable);
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> readable);
endmodule

bind ring_ptr_ctrl ring_ptr_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .BASE   (BASE),
  .DEPTH  (DEPTH),
  .RD_TH  (RD_TH),
  .WR_TH  (WR_TH),
  .LVL_W  (LVL_W)
) u_chk (.*);

// File: tb/ring_ptr_ctrl_bench.sv
module ring_ptr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int B0 = 0,  D0 = 16, RT0 = 0, WT0 = 16;
  localparam int B1 = 8,  D1 = 12, RT1 = 3, WT1 = 9;
  localparam int LW0 = $clog2(D0) + 1;
  localparam int LW1 = $clog2(D1) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic w0 = 1'b0, r0 = 1'b0, w1 = 1'b0, r1 = 1'b0;
  logic [AW-1:0] wa0, ra0, wa1, ra1;
  logic [LW0-1:0] lv0;
  logic [LW1-1:0] lv1;
  logic wf0, rf0, wf1, rf1;

  int n_checks = 0;
  int n_fail = 0;

  // Bench model: index and level per instance.
  int m_wi [2];
  int m_ri [2];
  int m_lv [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_ptr_ctrl #(.ADDR_W(AW)) u_ring_ptr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(w0), .rd_stb(r0),
    .wr_addr(wa0), .rd_addr(ra0), .level(lv0),
    .writable(wf0), .readable(rf0));

  ring_ptr_ctrl #(.ADDR_W(AW), .BASE(32'(B1)), .DEPTH(D1),
                  .RD_TH(RT1), .WR_TH(WT1)) u_ring_ptr_ctrl_thr (
    .clk(clk), .rst_n(rst_n), .wr_stb(w1), .rd_stb(r1),
    .wr_addr(wa1), .rd_addr(ra1), .level(lv1),
    .writable(wf1), .readable(rf1));

  function automatic int ring_step(int i, int d);
    return (i + 1) % d;
  endfunction

  function automatic int count_step(int l, bit w, bit r);
    return l + (w ? 1 : 0) - (r ? 1 : 0);
  endfunction

  function automatic bit may_store(int l, int th);
    return l < th;
  endfunction

  function automatic bit may_fetch(int l, int th);
    return l > th;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2/R4 inst0 wr_addr", int'(wa0), B0 + m_wi[0]);
    check("R3/R4 inst0 rd_addr", int'(ra0), B0 + m_ri[0]);
    check("R5/R6/R7 inst0 level", int'(lv0), m_lv[0]);
    check("R8/R10 inst0 writable", int'(wf0), int'(may_store(m_lv[0], WT0)));
    check("R9/R10 inst0 readable", int'(rf0), int'(may_fetch(m_lv[0], RT0)));
    check("R12 inst0 level in range", int'(m_lv[0] >= 0 && int'(lv0) <= D0), 1);
    check("R2/R4 inst1 wr_addr", int'(wa1), B1 + m_wi[1]);
    check("R3/R4 inst1 rd_addr", int'(ra1), B1 + m_ri[1]);
    check("R5/R6/R7 inst1 level", int'(lv1), m_lv[1]);
    check("R8 inst1 writable", int'(wf1), int'(may_store(m_lv[1], WT1)));
    check("R9 inst1 readable", int'(rf1), int'(may_fetch(m_lv[1], RT1)));
  endtask

  // Called just after a falling edge; strobes are masked by the model flags.
  task automatic step(bit a0, bit b0, bit a1, bit b1);
    bit sw0, sr0, sw1, sr1;
    sw0 = a0 && may_store(m_lv[0], WT0);
    sr0 = b0 && may_fetch(m_lv[0], RT0);
    sw1 = a1 && may_store(m_lv[1], WT1);
    sr1 = b1 && may_fetch(m_lv[1], RT1);
    w0 = sw0; r0 = sr0; w1 = sw1; r1 = sr1;
    @(posedge clk);
    if (sw0) m_wi[0] = ring_step(m_wi[0], D0);
    if (sr0) m_ri[0] = ring_step(m_ri[0], D0);
    m_lv[0] = count_step(m_lv[0], sw0, sr0);
    if (sw1) m_wi[1] = ring_step(m_wi[1], D1);
    if (sr1) m_ri[1] = ring_step(m_ri[1], D1);
    m_lv[1] = count_step(m_lv[1], sw1, sr1);
    @(negedge clk);
    w0 = 1'b0; r0 = 1'b0; w1 = 1'b0; r1 = 1'b0;
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 2; k++) begin m_wi[k] = 0; m_ri[k] = 0; m_lv[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    check("R1 wr_addr in reset", int'(wa0), B0);
    check("R1 rd_addr in reset", int'(ra1), B1);
    check("R1 level in reset", int'(lv1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    check("R1 wr_addr after reset", int'(wa1), B1);

    // Fill instance 0 to its depth with writes alone.
    for (int k = 0; k < D0; k++) step(1'b1, 1'b0, 1'b1, 1'b0);
    check("R11 level reaches depth", int'(lv0), D0);
    check("R10 writable low when full", int'(wf0), 0);
    check("R8 inst1 stops at threshold", int'(lv1), WT1);

    // Drain to mid level, then wrap both pointers with joint strobes.
    for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 1'b1, 1'b1);
    check("R7 level held through joint strobes", int'(lv0), 8);
    check("R4 inst0 wr_addr after wrap", int'(wa0), B0 + ((D0 + 20) % D0));

    // Drain fully.
    for (int k = 0; k < D0; k++) step(1'b0, 1'b1, 1'b0, 1'b1);
    check("R10 readable low when empty", int'(rf0), 0);
    check("R6 level at zero", int'(lv0), 0);
    check("R9 inst1 holds at threshold", int'(lv1), RT1);

    // Seeded random legal traffic.
    for (int k = 0; k < 3000; k++)
      step(($urandom % 100) < 55, ($urandom % 100) < 50,
           ($urandom % 100) < 50, ($urandom % 100) < 55);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule